// File: doc/BRIEF.md
# Packed Integer Vector Execution Unit

This block is a 128-bit integer vector execution slice for a processor datapath. Each accepted request carries an opcode, two 128-bit source vectors and a 128-bit selector vector. The unit returns a 128-bit result together with a zero flag and a carry flag. It performs five packed operations:

- a masked bit test that only produces flags;
- a per-byte select steered by the top bit of each selector byte;
- a signed widening multiply of the even 32-bit lanes;
- a per-lane 64-bit equality compare;
- a search for the smallest unsigned 16-bit word and its position.

Requests are captured in an input register stage. The selected operation is computed combinationally. The outcome is captured in an output register stage, so a request appears at the outputs two clock cycles after it is taken. The outputs keep their last value until the next request completes. A new request may be issued every cycle.

Top module: `vsimd_exec`

## Requirements
- R1: While `rst` is sampled high, and on the first cycle after it is released, `out_valid`, `result`, `flag_z` and `flag_c` are all zero.
- R2: When `in_valid` is sampled high on a rising edge, `out_valid` is high for exactly one cycle, two rising edges later, carrying that request's outcome. While no request completes, `result`, `flag_z` and `flag_c` hold their previous values.
- R3: Opcode encoding on `in_op`: 0 is bit test, 1 is byte select, 2 is widening multiply, 3 is quadword compare, 4 is word minimum. Codes 5, 6 and 7 produce a zero result with both flags cleared.
- R4: For opcode 0, `flag_z` is 1 exactly when `src_a AND src_b` is all zeros.
- R5: For opcode 0, `flag_c` is 1 exactly when `src_b AND NOT src_a` is all zeros.
- R6: For opcode 0, `result` is all zeros, since the test writes no vector.
- R7: For opcode 1, result byte i (bits 8i+7:8i, i = 0..15) is taken from `src_b` when bit 8i+7 of `src_m` is 1, and from `src_a` when it is 0.
- R8: For opcode 2, result bits 63:0 hold the signed 64-bit product of `src_a[31:0]` and `src_b[31:0]`. Result bits 127:64 hold the signed product of `src_a[95:64]` and `src_b[95:64]`.
- R9: For opcode 3, result bits 63:0 are all ones when the two sources' bits 63:0 are equal and all zeros otherwise. Bits 127:64 follow the same rule for the upper 64-bit lane.
- R10: For opcode 4, result bits 15:0 hold the smallest unsigned 16-bit word of `src_a` (word k is bits 16k+15:16k). Bits 18:16 hold its index k, and bits 127:19 are zero.
- R11: For opcode 4, when several words share the smallest value, the lowest index is reported.
- R12: For every opcode other than 0, both `flag_z` and `flag_c` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation code |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| src_m | input | 128 | Selector vector for the byte select |
| out_valid | output | 1 | Outcome of a request is on the outputs |
| result | output | 128 | Vector result |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bit test is driven with disjoint operands, with a second source contained in the first, with overlapping operands and with all-zero operands, so that the four combinations of the two flags are separated. The multiply uses the most negative value squared, mixed signs and garbage in the odd lanes. These patterns show whether sign extension is applied and whether the right lanes are picked. The minimum search is tried with the minimum in the last word, with all words equal and with a tie between two inner words, which exposes scan order and tie handling. Random vectors for every opcode, checked against a bench-side model, plus the illegal codes and a hold check round out the coverage of the selects.

// File: rtl/vsimd_pkg.sv
package vsimd_pkg;

    localparam int VEC_W  = 128;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int DW_W   = 32;
    localparam int QW_W   = 64;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_TEST  = 3'd0,
        OP_BLEND = 3'd1,
        OP_MULW  = 3'd2,
        OP_CMPQ  = 3'd3,
        OP_MINW  = 3'd4
    } op_e;

    typedef struct packed {
        logic [VEC_W-1:0] res;
        logic             z;
        logic             c;
    } exec_out_t;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [VEC_W-1:0] a;
        logic [VEC_W-1:0] b;
        logic [VEC_W-1:0] m;
    } exec_req_t;

    function automatic logic all_zero(input logic [VEC_W-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/vsimd_logic_unit.sv
module vsimd_logic_unit
    import vsimd_pkg::*;
#(
    parameter int W      = VEC_W,
    parameter int BW     = BYTE_W,
    parameter int QW     = QW_W,
    localparam int NB    = W / BW,
    localparam int NQ    = W / QW
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [NB-1:0] byte_sel,
    output logic          test_z,
    output logic          test_c,
    output logic [W-1:0]  blend_res,
    output logic [W-1:0]  cmpq_res
);

    logic [W-1:0] and_ab;
    logic [W-1:0] andn_ab;

    assign and_ab  = a & b;
    assign andn_ab = b & ~a;
    assign test_z  = (and_ab == '0);
    assign test_c  = (andn_ab == '0);

    for (genvar gi = 0; gi < NB; gi++) begin : g_byte
        assign blend_res[gi*BW +: BW] = byte_sel[gi] ? b[gi*BW +: BW]
                                                      : a[gi*BW +: BW];
    end

    for (genvar gq = 0; gq < NQ; gq++) begin : g_qlane
        logic eq;
        assign eq = (a[gq*QW +: QW] == b[gq*QW +: QW]);
        assign cmpq_res[gq*QW +: QW] = {QW{eq}};
    end

endmodule

// File: rtl/vsimd_mul_unit.sv
module vsimd_mul_unit
    import vsimd_pkg::*;
#(
    parameter int LANES = VEC_W / QW_W,
    parameter int DW    = DW_W,
    localparam int PW   = 2 * DW
) (
    input  logic [LANES*DW-1:0] a_even,
    input  logic [LANES*DW-1:0] b_even,
    output logic [LANES*PW-1:0] prod
);

    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        logic signed [DW-1:0] x;
        logic signed [DW-1:0] y;
        logic signed [PW-1:0] p;
        assign x = a_even[gl*DW +: DW];
        assign y = b_even[gl*DW +: DW];
        assign p = PW'(x) * PW'(y);
        assign prod[gl*PW +: PW] = p;
    end

endmodule

// File: rtl/vsimd_minpos_unit.sv
module vsimd_minpos_unit
    import vsimd_pkg::*;
#(
    parameter int W      = VEC_W,
    parameter int WW     = WORD_W,
    localparam int NW    = W / WW,
    localparam int IDX_W = $clog2(NW)
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] res
);

    logic [WW-1:0]    best_val;
    logic [IDX_W-1:0] best_idx;

    always_comb begin
        best_val = a[WW-1:0];
        best_idx = '0;
        for (int k = 1; k < NW; k++) begin
            if (a[k*WW +: WW] < best_val) begin
                best_val = a[k*WW +: WW];
                best_idx = IDX_W'(k);
            end
        end
    end

    always_comb begin
        res = '0;
        res[WW-1:0]       = best_val;
        res[WW +: IDX_W]  = best_idx;
    end

endmodule

// File: rtl/vsimd_exec.sv
module vsimd_exec
    import vsimd_pkg::*;
#(
    parameter int W     = VEC_W,
    localparam int NB   = W / BYTE_W,
    localparam int NQ   = W / QW_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_op,
    input  logic [W-1:0]    src_a,
    input  logic [W-1:0]    src_b,
    input  logic [W-1:0]    src_m,
    output logic            out_valid,
    output logic [W-1:0]    result,
    output logic            flag_z,
    output logic            flag_c
);

    exec_req_t req_q;
    logic      req_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_v_q <= 1'b0;
            req_q   <= '0;
        end else begin
            req_v_q <= in_valid;
            if (in_valid) begin
                req_q.op <= in_op;
                req_q.a  <= src_a;
                req_q.b  <= src_b;
                req_q.m  <= src_m;
            end
        end
    end

    logic [NB-1:0]      byte_sel;
    logic [NQ*DW_W-1:0] a_even;
    logic [NQ*DW_W-1:0] b_even;
    logic [NQ*DW_W-1:0] a_odd;
    logic [NQ*DW_W-1:0] b_odd;
    logic [W-NB-1:0]    m_low;

    for (genvar gi = 0; gi < NB; gi++) begin : g_sel
        assign byte_sel[gi] = req_q.m[gi*BYTE_W + BYTE_W - 1];
        assign m_low[gi*(BYTE_W-1) +: BYTE_W-1] = req_q.m[gi*BYTE_W +: BYTE_W-1];
    end

    for (genvar gl = 0; gl < NQ; gl++) begin : g_even
        assign a_even[gl*DW_W +: DW_W] = req_q.a[gl*QW_W +: DW_W];
        assign b_even[gl*DW_W +: DW_W] = req_q.b[gl*QW_W +: DW_W];
        assign a_odd[gl*DW_W +: DW_W]  = req_q.a[gl*QW_W + DW_W +: DW_W];
        assign b_odd[gl*DW_W +: DW_W]  = req_q.b[gl*QW_W + DW_W +: DW_W];
    end

    logic unused_bits;
    assign unused_bits = ^{a_odd, b_odd, m_low};

    logic          t_z, t_c;
    logic [W-1:0]  blend_res, cmpq_res, mul_res, min_res;

    vsimd_logic_unit #(.W(W)) u_logic (
        .a         (req_q.a),
        .b         (req_q.b),
        .byte_sel  (byte_sel),
        .test_z    (t_z),
        .test_c    (t_c),
        .blend_res (blend_res),
        .cmpq_res  (cmpq_res)
    );

    vsimd_mul_unit #(.LANES(NQ)) u_mul (
        .a_even (a_even),
        .b_even (b_even),
        .prod   (mul_res)
    );

    vsimd_minpos_unit #(.W(W)) u_minpos (
        .a   (req_q.a),
        .res (min_res)
    );

    exec_out_t nxt;

    always_comb begin
        nxt = '0;
        case (req_q.op)
            OP_TEST: begin
                nxt.z = t_z;
                nxt.c = t_c;
            end
            OP_BLEND: nxt.res = blend_res;
            OP_MULW:  nxt.res = mul_res;
            OP_CMPQ:  nxt.res = cmpq_res;
            OP_MINW:  nxt.res = min_res;
            default:  nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_z    <= 1'b0;
            flag_c    <= 1'b0;
        end else begin
            out_valid <= req_v_q;
            if (req_v_q) begin
                result <= nxt.res;
                flag_z <= nxt.z;
                flag_c <= nxt.c;
            end
        end
    end

endmodule

// File: rtl/vsimd_exec_chk.sv
module vsimd_exec_chk
    import vsimd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  in_op,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic [VEC_W-1:0] src_m,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic             flag_z,
    input logic             flag_c
);

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    assert_test_zf_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_TEST && (src_a & src_b) == '0) |=> ##1 flag_z);

    assert_test_cf_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_TEST && (src_b & ~src_a) != '0) |=> ##1 !flag_c);

    assert_test_no_vector_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_TEST) |=> ##1 (result == '0));

    assert_blend_zero_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_BLEND && src_m == '0) |=> ##1 (result == $past(src_a, 2)));

    assert_cmpq_lanes_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_CMPQ) |=>
        ##1 ((result[63:0] == '0 || result[63:0] == '1) &&
             (result[127:64] == '0 || result[127:64] == '1)));

    assert_minw_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_MINW) |=> ##1 (result[127:19] == '0));

    assert_flags_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != OP_TEST) |=> ##1 (!flag_z && !flag_c));

endmodule

bind vsimd_exec vsimd_exec_chk u_chk (.*);

// File: tb/vsimd_exec_tb.sv
module vsimd_exec_tb;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   in_op;
    logic [127:0] src_a, src_b, src_m;
    logic         out_valid;
    logic [127:0] result;
    logic         flag_z, flag_c;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsimd_exec u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .src_a(src_a), .src_b(src_b), .src_m(src_m),
        .out_valid(out_valid), .result(result),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%032h expected=%032h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic model(input logic [2:0] op, input logic [127:0] a,
                         input logic [127:0] b, input logic [127:0] m,
                         output logic [127:0] r, output logic z, output logic c);
        longint p;
        logic [15:0] mv;
        int mi;
        r = '0; z = 1'b0; c = 1'b0;
        case (op)
            3'd0: begin
                z = ((a & b) == 128'd0);
                c = ((b & ~a) == 128'd0);
            end
            3'd1: for (int i = 0; i < 16; i++)
                      r[i*8 +: 8] = m[i*8+7] ? b[i*8 +: 8] : a[i*8 +: 8];
            3'd2: for (int l = 0; l < 2; l++) begin
                      p = longint'(int'(a[l*64 +: 32])) * longint'(int'(b[l*64 +: 32]));
                      r[l*64 +: 64] = p;
                  end
            3'd3: for (int l = 0; l < 2; l++)
                      r[l*64 +: 64] = (a[l*64 +: 64] == b[l*64 +: 64]) ? {64{1'b1}} : 64'd0;
            3'd4: begin
                mv = 16'hFFFF; mi = 0;
                for (int k = 7; k >= 0; k--)
                    if (a[k*16 +: 16] <= mv) begin mv = a[k*16 +: 16]; mi = k; end
                r[15:0] = mv;
                r[18:16] = 3'(mi);
            end
            default: ;
        endcase
    endtask

    task automatic run_op(input logic [2:0] op, input logic [127:0] a,
                          input logic [127:0] b, input logic [127:0] m,
                          input string tag);
        logic [127:0] er;
        logic ez, ec;
        model(op, a, b, m, er, ez, ec);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; src_a = a; src_b = b; src_m = m;
        @(negedge clk);
        in_valid = 1'b0; src_a = rnd128(); src_b = rnd128(); src_m = rnd128();
        @(negedge clk);
        check(out_valid === 1'b1, {tag, " R2 out_valid"}, 128'(out_valid), 128'd1);
        check(result === er, {tag, " result"}, result, er);
        check(flag_z === ez, {tag, " flag_z"}, 128'(flag_z), 128'(ez));
        check(flag_c === ec, {tag, " flag_c"}, 128'(flag_c), 128'(ec));
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_op = '0;
        src_a = '0; src_b = '0; src_m = '0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid in reset", 128'(out_valid), 128'd0);
        check(result === '0, "R1 result in reset", result, '0);
        check({flag_z, flag_c} === 2'b00, "R1 flags in reset", 128'({flag_z, flag_c}), 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid after reset", 128'(out_valid), 128'd0);
    endtask

    task automatic t_test();
        logic [127:0] x = 128'hF0F0_0000_1234_5678_0000_FFFF_0F0F_AAAA;
        run_op(3'd0, x, ~x, '0, "R4 R5 R6 test disjoint");
        run_op(3'd0, x, x & 128'h00FF_00FF_00FF_00FF_00FF_00FF_00FF_00FF, '0,
               "R4 R5 R6 test subset");
        run_op(3'd0, x, x | 128'h1, '0, "R4 R5 test overlap");
        run_op(3'd0, '0, '0, '0, "R4 R5 test zeros");
        run_op(3'd0, '1, 128'h8000_0000_0000_0000_0000_0000_0000_0000, '0,
               "R4 R5 test top bit");
    endtask

    task automatic t_blend();
        logic [127:0] a = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
        logic [127:0] b = 128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100;
        run_op(3'd1, a, b, '0, "R7 blend no select");
        run_op(3'd1, a, b, {16{8'h80}}, "R7 blend all select");
        run_op(3'd1, a, b, {8{16'h7F80}}, "R7 blend alternate msb only");
        run_op(3'd1, a, b, {16{8'h7F}}, "R7 blend low bits ignored");
    endtask

    task automatic t_mul();
        run_op(3'd2, {32'hDEAD_BEEF, 32'h0000_0003, 32'h1234_5678, 32'h8000_0000},
                     {32'hCAFE_F00D, 32'hFFFF_FFFF, 32'h9ABC_DEF0, 32'h8000_0000},
               '0, "R8 mul neg squared and mixed sign");
        run_op(3'd2, {32'h0, 32'h7FFF_FFFF, 32'h0, 32'hFFFF_FFFF},
                     {32'h0, 32'h7FFF_FFFF, 32'h0, 32'h0000_0001},
               '0, "R8 mul max pos and minus one");
    endtask

    task automatic t_cmpq();
        logic [127:0] a = rnd128();
        run_op(3'd3, a, a, '0, "R9 cmpq both equal");
        run_op(3'd3, a, a ^ 128'h1, '0, "R9 cmpq low differs");
        run_op(3'd3, a, a ^ {1'b1, 127'd0}, '0, "R9 cmpq high differs");
    endtask

    task automatic t_minw();
        run_op(3'd4, {16'h0001, 16'h0005, 16'h0009, 16'hFFFF,
                      16'h8000, 16'h0777, 16'h0100, 16'h0002}, '0, '0, "R10 min in word 7");
        run_op(3'd4, {8{16'h4242}}, '0, '0, "R11 all words equal");
        run_op(3'd4, {16'h9000, 16'h0030, 16'h9000, 16'h9000,
                      16'h0030, 16'h9000, 16'h9000, 16'hFFFF}, '0, '0, "R11 tie inner words");
        run_op(3'd4, {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF,
                      16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}, '0, '0, "R10 all max");
    endtask

    task automatic t_illegal();
        for (int op = 5; op < 8; op++)
            run_op(3'(op), rnd128(), rnd128(), rnd128(), "R3 R12 illegal code");
    endtask

    task automatic t_hold();
        logic [127:0] r0;
        logic z0, c0;
        run_op(3'd0, 128'hF, 128'h10, '0, "R2 hold setup");
        r0 = result; z0 = flag_z; c0 = flag_c;
        src_a = '1; src_b = '1; in_op = 3'd4;
        repeat (3) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R2 no spurious valid", 128'(out_valid), 128'd0);
            check(result === r0 && flag_z === z0 && flag_c === c0,
                  "R2 outputs hold", result, r0);
        end
    endtask

    task automatic t_random();
        for (int n = 0; n < 60; n++)
            run_op(3'(n % 5), rnd128(), rnd128(), rnd128(), "R3 R12 random");
    endtask

    initial begin
        t_reset();
        t_test();
        t_blend();
        t_mul();
        t_cmpq();
        t_minw();
        t_illegal();
        t_hold();
        t_random();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (50000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog R2 actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule